// File: doc/BRIEF.md
# Three-Wire Cascadable Wiper-Setting Register

This block is the digital side of a dual 256-step potentiometer. A host drives three lines: an active-high enable, a serial clock and a serial data line. While the enable is high, each rising serial clock moves one data bit into a 17-bit frame register. When the enable returns low, the frame is copied into two 8-bit tap codes and a one-bit stack selector. These latched values drive the resistor-ladder multiplexers, which lie outside this block.

The bit leaving the far end of the frame register is driven onto a cascade output. A second device can take that output as its data input, so several devices share one three-wire bus as a daisy chain. With the two ladders wired in series, the stack selector picks which wiper feeds the combined output. The block reports that choice as a 9-bit position code covering 512 steps.

All three serial lines are asynchronous to the system clock. They are synchronised first, and the serial-clock rise and the enable fall are then turned into single-cycle strobes.

Top module: `tw_wiper_reg`

## Requirements
- R1: A synchronous reset clears both tap codes, the stack selector, the cascade output and the 9-bit stacked code to 0.
- R2: While the enable is low, serial clock edges shift nothing. After such edges, the cascade output is unchanged, and an enable pulse with no clock edges latches the previously held values.
- R3: While the enable is high, each rising serial clock shifts the data bit in. A 17-bit frame sent in this order is latched as follows: the stack bit, then tap 1 MSB first, then tap 0 MSB first. Frame bit 0 becomes the stack selector. Bits 1..8 become tap 1, with its MSB at bit 1. Bits 9..16 become tap 0, with its MSB at bit 9.
- R4: Tap codes and the stack selector keep their old values for the whole of a transaction. They change only when the enable falls.
- R5: A transaction that does not carry a multiple of 17 bits still latches whatever the frame register holds when the enable falls. No error is raised.
- R6: The cascade output always equals frame bit 0. When idle after a full frame, this is the stack bit. Each shift presents the next stored bit, so 17 clocks pass the previous frame out in the order it was sent.
- R7: The stacked code is {1'b0, tap0} when the stack selector is 0, and {1'b1, tap1} when it is 1.
- R8: When more than 17 bits are sent in one transaction, only the last 17 bits are latched.
- R9: Suppose an enable fall is driven between system clock edges. The latched outputs still show the old values after the 2nd rising system edge that follows, and show the new values after the 3rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Serial port enable, active high, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in |
| casc_out | output | 1 | Cascade data out (frame bit 0) |
| tap0_code | output | 8 | Latched tap code of ladder 0 |
| tap1_code | output | 8 | Latched tap code of ladder 1 |
| stack_sel | output | 1 | Latched stack selector |
| stack_code | output | 9 | Combined stacked position |

## Verification
Any serial line change reaches the frame register on the third rising system edge after the change: two edges pass through the synchroniser and one through the edge register. The cascade output follows the frame register without further delay. An enable fall reaches the tap codes on that same third edge. The bench drives every serial edge on a falling system edge. It samples the cascade output four system cycles after each serial clock rise, and the latched outputs five cycles after the enable fall. A separate check samples two and three edges after an enable fall to fix the R9 latency exactly.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned TAP_W   = 8;
  localparam int unsigned FRAME_W = 2 * TAP_W + 1;
  localparam int unsigned SEL_POS = 0;
  localparam int unsigned T1_LO   = 1;
  localparam int unsigned T0_LO   = 1 + TAP_W;

  typedef logic [TAP_W-1:0]   tap_t;
  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [TAP_W:0]     stk_t;

  // Tap code held MSB-first starting at frame bit lo.
  function automatic tap_t frame_tap(frame_t f, int unsigned lo);
    tap_t t;
    for (int i = 0; i < TAP_W; i++) begin
      t[TAP_W-1-i] = f[lo+i];
    end
    return t;
  endfunction

  // Combined 512-step position: ladder index on top, tap code below.
  function automatic stk_t stack_pos(logic sel, tap_t t0, tap_t t1);
    return sel ? {1'b1, t1} : {1'b0, t0};
  endfunction
endpackage

// File: rtl/tw_in_sync.sv
module tw_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_en,
  input  logic ser_din,
  output logic shift_stb,
  output logic latch_stb,
  output logic din_s
);
  localparam int unsigned NLINE = 3;

  logic [NLINE-1:0] stg [STAGES];
  logic             clk_prev;
  logic             en_prev;
  logic             clk_s;
  logic             en_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      clk_prev <= 1'b0;
      en_prev  <= 1'b0;
    end else begin
      stg[0] <= {ser_din, ser_en, ser_clk};
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      clk_prev <= clk_s;
      en_prev  <= en_s;
    end
  end

  assign clk_s     = stg[STAGES-1][0];
  assign en_s      = stg[STAGES-1][1];
  assign din_s     = stg[STAGES-1][2];
  assign shift_stb = clk_s & ~clk_prev & en_s;
  assign latch_stb = ~en_s & en_prev;
endmodule

// File: rtl/tw_shift_chain.sv
module tw_shift_chain
  import tw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift_stb,
  input  logic   din_s,
  output frame_t sr_q,
  output logic   casc_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_stb) begin
      sr_q <= {din_s, sr_q[FRAME_W-1:1]};
    end
  end

  assign casc_out = sr_q[SEL_POS];
endmodule

// File: rtl/tw_wiper_hold.sv
module tw_wiper_hold
  import tw_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   latch_stb,
  input  frame_t sr_q,
  output tap_t   tap0_q,
  output tap_t   tap1_q,
  output logic   sel_q,
  output stk_t   stk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap0_q <= '0;
      tap1_q <= '0;
      sel_q  <= 1'b0;
    end else if (latch_stb) begin
      tap0_q <= frame_tap(sr_q, T0_LO);
      tap1_q <= frame_tap(sr_q, T1_LO);
      sel_q  <= sr_q[SEL_POS];
    end
  end

  assign stk_q = stack_pos(sel_q, tap0_q, tap1_q);
endmodule

// File: rtl/tw_wiper_reg.sv
module tw_wiper_reg
  import tw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_en,
  input  logic             ser_clk,
  input  logic             ser_din,
  output logic             casc_out,
  output logic [TAP_W-1:0] tap0_code,
  output logic [TAP_W-1:0] tap1_code,
  output logic             stack_sel,
  output logic [TAP_W:0]   stack_code
);
  logic   shift_stb;
  logic   latch_stb;
  logic   din_s;
  frame_t sr_q;

  tw_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
    .shift_stb(shift_stb), .latch_stb(latch_stb), .din_s(din_s)
  );

  tw_shift_chain i_chain (
    .clk(clk), .rst(rst), .shift_stb(shift_stb), .din_s(din_s),
    .sr_q(sr_q), .casc_out(casc_out)
  );

  tw_wiper_hold i_hold (
    .clk(clk), .rst(rst), .latch_stb(latch_stb), .sr_q(sr_q),
    .tap0_q(tap0_code), .tap1_q(tap1_code), .sel_q(stack_sel), .stk_q(stack_code)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker
  import tw_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             shift_stb,
  input logic             latch_stb,
  input frame_t           sr_q,
  input logic             casc_out,
  input logic [TAP_W-1:0] tap0_code,
  input logic [TAP_W-1:0] tap1_code,
  input logic             stack_sel,
  input logic [TAP_W:0]   stack_code
);
  // R4
  hold_tap0_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_stb |=> $stable(tap0_code));
  // R4
  hold_tap1_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_stb |=> $stable(tap1_code) && $stable(stack_sel));
  // R2
  idle_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_stb |=> $stable(sr_q));
  // R6
  casc_step_chk: assert property (@(posedge clk) disable iff (rst)
    shift_stb |=> casc_out == $past(sr_q[1]));
  // R3
  tap_msb_chk: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> tap1_code[TAP_W-1] == $past(sr_q[T1_LO]) &&
                  tap0_code[TAP_W-1] == $past(sr_q[T0_LO]) &&
                  stack_sel == $past(sr_q[SEL_POS]));
  // R7
  stack_top_chk: assert property (@(posedge clk) disable iff (rst)
    stack_code[TAP_W] == stack_sel);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(shift_stb && latch_stb));
endmodule

bind tw_wiper_reg tw_checker i_chk (
  .clk(clk), .rst(rst), .shift_stb(shift_stb), .latch_stb(latch_stb), .sr_q(sr_q),
  .casc_out(casc_out), .tap0_code(tap0_code), .tap1_code(tap1_code),
  .stack_sel(stack_sel), .stack_code(stack_code)
);

// File: tb/test_tw_wiper_reg.sv
module test_tw_wiper_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_en = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       casc_out;
  logic [7:0] tap0_code;
  logic [7:0] tap1_code;
  logic       stack_sel;
  logic [8:0] stack_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [16:0] m_sr = '0;
  int m_t0 = 0, m_t1 = 0, m_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_wiper_reg i_tw_wiper_reg (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .casc_out(casc_out), .tap0_code(tap0_code), .tap1_code(tap1_code),
    .stack_sel(stack_sel), .stack_code(stack_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Tap value from model register: MSB at bit lo, weights halve upward.
  function automatic int model_tap(input int lo);
    int v = 0;
    for (int i = 0; i < 8; i++) v = v * 2 + int'(m_sr[lo+i]);
    return v;
  endfunction

  task automatic model_latch();
    m_t1  = model_tap(1);
    m_t0  = model_tap(9);
    m_sel = int'(m_sr[0]);
  endtask

  task automatic check_outs(input string req);
    chk({req, " tap0"}, int'(tap0_code), m_t0);
    chk({req, " tap1"}, int'(tap1_code), m_t1);
    chk({req, " sel"},  int'(stack_sel), m_sel);
    // R7: 256 * selector plus the chosen tap
    chk("R7 stack", int'(stack_code), m_sel * 256 + (m_sel != 0 ? m_t1 : m_t0));
  endtask

  task automatic ser_bit(input logic b);
    ser_din = b;
    wait_n(3);
    ser_clk = 1'b1;
    wait_n(4);
    m_sr = {b, m_sr[16:1]};
    // R6: next stored bit now on cascade output
    chk("R6 casc", int'(casc_out), int'(m_sr[0]));
    ser_clk = 1'b0;
    wait_n(3);
  endtask

  task automatic tx_begin();
    ser_en = 1'b1;
    wait_n(4);
  endtask

  task automatic tx_end();
    ser_en = 1'b0;
    wait_n(5);
    model_latch();
  endtask

  task automatic send_frame(input logic sel, input logic [7:0] t1, input logic [7:0] t0);
    ser_bit(sel);
    for (int i = 7; i >= 0; i--) ser_bit(t1[i]);
    for (int i = 7; i >= 0; i--) ser_bit(t0[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R1
    chk("R1 casc", int'(casc_out), 0);
    check_outs("R1");

    // R3 / R7 sweep over all tap 0 codes
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kk;
      kk = 8'(k);
      tx_begin();
      send_frame(kk[0] ^ kk[3], kk ^ 8'hA5, kk);
      tx_end();
      check_outs("R3");
      chk("R3 tap0 value", int'(tap0_code), k);
    end

    // R4: outputs hold mid-transaction
    tx_begin();
    ser_bit(1'b1);
    for (int i = 0; i < 9; i++) ser_bit(1'b0);
    check_outs("R4");
    for (int i = 0; i < 7; i++) ser_bit(1'b1);
    check_outs("R4");
    tx_end();
    check_outs("R4 after");
    chk("R4 sel new", int'(stack_sel), 1);

    // R6: idle cascade output shows the stack bit
    chk("R6 idle", int'(casc_out), int'(stack_sel));

    // R2: clock edges while disabled shift nothing
    for (int i = 0; i < 5; i++) begin
      ser_din = ~m_sr[0];
      wait_n(3);
      ser_clk = 1'b1;
      wait_n(4);
      chk("R2 casc", int'(casc_out), int'(m_sr[0]));
      ser_clk = 1'b0;
      wait_n(3);
    end
    tx_begin();
    tx_end();
    check_outs("R2");

    // R5: partial frame of five bits
    tx_begin();
    for (int i = 0; i < 5; i++) ser_bit(1'(i % 2));
    tx_end();
    check_outs("R5");

    // R8: two frames in one transaction, second wins
    tx_begin();
    send_frame(1'b0, 8'h3C, 8'h81);
    send_frame(1'b1, 8'hE7, 8'h42);
    tx_end();
    check_outs("R8");
    chk("R8 tap1", int'(tap1_code), 'hE7);
    chk("R8 tap0", int'(tap0_code), 'h42);

    // R9: latency of the enable fall
    tx_begin();
    send_frame(1'b0, 8'h11, 8'hF0);
    ser_en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_outs("R9 old");
    model_latch();
    @(negedge clk);
    check_outs("R9 new");

    // R1: reset mid-state
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(1);
    m_sr = '0;
    model_latch();
    check_outs("R1 again");
    chk("R1 casc again", int'(casc_out), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule